// File: doc/BRIEF.md
# Timer update and event generator

This block sits beside a timer counter and decides when the timer's update event fires. It also turns software-forced event requests into single-cycle strobes and keeps the status flags those events raise. An update can come from three sources: a counter wrap (overflow or underflow) once an internal repetition count has run down to zero, a software update request, or an external trigger that resets the counter. Each source gates the update flag by its own rule.

Software writes a 16-bit event word. Each set bit acts once and is then gone, so the word never needs to be cleared. The bits request a software update, a forced capture/compare on one of the channels, a commutation, a trigger, or a break. A break drives the main output enable low and raises the break flag. The enable is raised again only by an explicit set pulse. The three status flags (update, trigger, break) stay set until software clears them with a clear mask.

There is no data stream here. Every pin is a plain control or status signal, and there is no valid/ready handshake. Each output is registered: a stimulus that is present before a rising clock edge shows at the outputs just after that edge.

Top module: `tmr_evt_gen`

## Requirements
- R1: A wrap strobe (`wrap_i`) produces `upd_o` and sets `uif_o` on the next cycle only when the internal repetition count is zero and `upd_dis_i` is 0.
- R1 (repetition count): the repetition count starts at zero after reset. On a wrap it reloads from `rep_preset_i` when it is zero and otherwise decrements by one. A software update or a trigger reset also reloads it.
- R2: Event bit 0 (software update) gives `reinit_o` on the next cycle in all cases. It gives `upd_o` when `upd_dis_i` is 0. It sets `uif_o` only when both `upd_dis_i` and `upd_src_i` are 0.
- R3: A trigger reset strobe (`trig_rst_i`) has exactly the same effect as event bit 0.
- R4: While `upd_dis_i` is 1, no source produces `upd_o` and none sets `uif_o`.
- R5: The event word bits act as one-cycle strobes on the cycle after `evt_we_i`. Bits 4..1 pulse `ccg_o[3:0]` (bit k+1 drives channel k, so `ccg_o[k]`). Bit 5 pulses `comg_o`. Bits 15..8 have no effect, and a word presented while `evt_we_i` is 0 has no effect.
- R6: Event bit 7 (break) clears `moe_o` and sets `bif_o` on the next cycle. It wins over `moe_set_i` in the same cycle.
- R7: Event bit 6 (trigger) sets `tif_o` on the next cycle.
- R8: After reset all outputs are 0. The flags hold until `sts_clr_we_i` is asserted with `sts_clr_mask_i` (bit 0 = update, bit 1 = trigger, bit 2 = break). A set in the same cycle wins over the clear.
- R9: `moe_set_i` raises `moe_o` on the next cycle when no break is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrap_i | input | 1 | Counter overflow/underflow strobe |
| rep_preset_i | input | RW | Repetition count reload value |
| trig_rst_i | input | 1 | External trigger counter-reset strobe |
| upd_dis_i | input | 1 | Update disable |
| upd_src_i | input | 1 | Update request source: 1 keeps software/trigger reinitialises out of the update flag |
| evt_we_i | input | 1 | Event word write strobe |
| evt_wdata_i | input | 16 | Event word |
| sts_clr_we_i | input | 1 | Flag clear strobe |
| sts_clr_mask_i | input | 3 | Flags to clear: bit 0 update, bit 1 trigger, bit 2 break |
| moe_set_i | input | 1 | Raise main output enable |
| upd_o | output | 1 | Update event pulse |
| reinit_o | output | 1 | Counter reinitialise pulse |
| ccg_o | output | NCH | Forced capture/compare strobes |
| comg_o | output | 1 | Forced commutation strobe |
| uif_o | output | 1 | Update flag |
| tif_o | output | 1 | Trigger flag |
| bif_o | output | 1 | Break flag |
| moe_o | output | 1 | Main output enable |

## Verification
A repetition count that is off by one moves the update pulse and the update flag to the wrong wrap. This shows at the ports within one preset period of wraps, so the bench counts several wraps against a non-zero preset. A flag register that loses or gains state shows as `uif_o`, `tif_o` or `bif_o` differing from the set/clear history one cycle after the event. The bench therefore checks that flags hold across idle cycles and clear selectively. A strobe that fails to clear itself shows as `ccg_o`, `comg_o` or `reinit_o` still high one cycle after the write.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int EVT_W  = 16;
  localparam int EB_UPD = 0;
  localparam int EB_CH0 = 1;
  localparam int EB_COM = 5;
  localparam int EB_TRG = 6;
  localparam int EB_BRK = 7;
  localparam int MAX_CH = EB_COM - EB_CH0;

  localparam int FL_UPD = 0;
  localparam int FL_TRG = 1;
  localparam int FL_BRK = 2;
  localparam int NFLAG  = 3;

  typedef struct packed {
    logic upd;
    logic com;
    logic trg;
    logic brk;
  } evt_req_t;
endpackage

// File: rtl/tmr_evt_decode.sv
module tmr_evt_decode
  import tmr_evt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             evt_we_i,
  input  logic [EVT_W-1:0] evt_wdata_i,
  output evt_req_t         req_o,
  output logic [NCH-1:0]   ch_o
);
  logic resv_unused;
  assign resv_unused = ^evt_wdata_i[EVT_W-1:EB_BRK+1];

  assign req_o.upd = evt_we_i & evt_wdata_i[EB_UPD];
  assign req_o.com = evt_we_i & evt_wdata_i[EB_COM];
  assign req_o.trg = evt_we_i & evt_wdata_i[EB_TRG];
  assign req_o.brk = evt_we_i & evt_wdata_i[EB_BRK];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_o[k] = evt_we_i & evt_wdata_i[EB_CH0 + k];
  end

  if (NCH < MAX_CH) begin : g_ch_spare
    logic spare_unused;
    assign spare_unused = ^evt_wdata_i[EB_COM-1:EB_CH0+NCH];
  end
endmodule

// File: rtl/tmr_rep_ctr.sv
module tmr_rep_ctr #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap_i,
  input  logic          reload_i,
  input  logic [RW-1:0] preset_i,
  output logic          zero_o
);
  logic [RW-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (reload_i || (wrap_i && zero_o)) cnt_q <= preset_i;
    else if (wrap_i)                   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/tmr_upd_ctrl.sv
module tmr_upd_ctrl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wrap_i,
  input  logic           rep_zero_i,
  input  logic           trig_rst_i,
  input  logic           sw_upd_i,
  input  logic           upd_dis_i,
  input  logic           upd_src_i,
  input  logic [NCH-1:0] ch_req_i,
  input  logic           com_req_i,
  output logic           upd_o,
  output logic           reinit_o,
  output logic [NCH-1:0] ccg_o,
  output logic           comg_o,
  output logic           uif_set_o
);
  logic wrap_upd, sw_reinit, upd_d;

  assign wrap_upd  = wrap_i & rep_zero_i;
  assign sw_reinit = sw_upd_i | trig_rst_i;
  assign upd_d     = ~upd_dis_i & (wrap_upd | sw_reinit);
  assign uif_set_o = ~upd_dis_i & (wrap_upd | (sw_reinit & ~upd_src_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_o    <= 1'b0;
      reinit_o <= 1'b0;
      ccg_o    <= '0;
      comg_o   <= 1'b0;
    end else begin
      upd_o    <= upd_d;
      reinit_o <= sw_reinit;
      ccg_o    <= ch_req_i;
      comg_o   <= com_req_i;
    end
  end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank
  import tmr_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic             moe_set_i,
  input  logic             brk_i,
  output logic [NFLAG-1:0] flag_o,
  output logic             moe_o
);
  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[f] <= 1'b0;
      else if (set_i[f]) flag_o[f] <= 1'b1;
      else if (clr_i[f]) flag_o[f] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         moe_o <= 1'b0;
    else if (brk_i)     moe_o <= 1'b0;
    else if (moe_set_i) moe_o <= 1'b1;
  end
endmodule

// File: rtl/tmr_evt_gen.sv
module tmr_evt_gen
  import tmr_evt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [RW-1:0]    rep_preset_i,
  input  logic             trig_rst_i,
  input  logic             upd_dis_i,
  input  logic             upd_src_i,
  input  logic             evt_we_i,
  input  logic [EVT_W-1:0] evt_wdata_i,
  input  logic             sts_clr_we_i,
  input  logic [NFLAG-1:0] sts_clr_mask_i,
  input  logic             moe_set_i,
  output logic             upd_o,
  output logic             reinit_o,
  output logic [NCH-1:0]   ccg_o,
  output logic             comg_o,
  output logic             uif_o,
  output logic             tif_o,
  output logic             bif_o,
  output logic             moe_o
);
  evt_req_t         req;
  logic [NCH-1:0]   ch_req;
  logic             rep_zero;
  logic             uif_set;
  logic [NFLAG-1:0] flag_set, flag_clr, flags;

  tmr_evt_decode #(.NCH(NCH)) u_dec (
    .evt_we_i(evt_we_i), .evt_wdata_i(evt_wdata_i), .req_o(req), .ch_o(ch_req)
  );

  tmr_rep_ctr #(.RW(RW)) u_rep (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_i),
    .reload_i(req.upd | trig_rst_i), .preset_i(rep_preset_i), .zero_o(rep_zero)
  );

  tmr_upd_ctrl #(.NCH(NCH)) u_upd (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_i), .rep_zero_i(rep_zero),
    .trig_rst_i(trig_rst_i), .sw_upd_i(req.upd), .upd_dis_i(upd_dis_i),
    .upd_src_i(upd_src_i), .ch_req_i(ch_req), .com_req_i(req.com),
    .upd_o(upd_o), .reinit_o(reinit_o), .ccg_o(ccg_o), .comg_o(comg_o),
    .uif_set_o(uif_set)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FL_UPD] = uif_set;
    flag_set[FL_TRG] = req.trg;
    flag_set[FL_BRK] = req.brk;
  end
  assign flag_clr = sts_clr_we_i ? sts_clr_mask_i : '0;

  tmr_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr),
    .moe_set_i(moe_set_i), .brk_i(req.brk), .flag_o(flags), .moe_o(moe_o)
  );

  assign uif_o = flags[FL_UPD];
  assign tif_o = flags[FL_TRG];
  assign bif_o = flags[FL_BRK];
endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wrap_i,
  input logic           rep_zero,
  input logic           trig_rst_i,
  input logic           upd_dis_i,
  input logic           upd_src_i,
  input logic           evt_we_i,
  input logic [15:0]    evt_wdata_i,
  input logic           moe_set_i,
  input logic           upd_o,
  input logic           reinit_o,
  input logic [NCH-1:0] ccg_o,
  input logic           comg_o,
  input logic           uif_o,
  input logic           tif_o,
  input logic           bif_o,
  input logic           moe_o
);
  p_wrap_upd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && rep_zero && !upd_dis_i) |=> (upd_o && uif_o));

  p_sw_reinit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_we_i && evt_wdata_i[0]) |=> reinit_o);

  p_trig_reinit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rst_i |=> reinit_o);

  p_src_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_i && upd_src_i && !uif_o) |=> !uif_o);

  p_dis_no_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis_i |=> !upd_o);

  p_strobe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_we_i |=> (ccg_o == '0 && !comg_o));

  p_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_we_i && evt_wdata_i[7]) |=> (!moe_o && bif_o));

  p_trig_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_we_i && evt_wdata_i[6]) |=> tif_o);

  p_moe_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (moe_set_i && !(evt_we_i && evt_wdata_i[7])) |=> moe_o);
endmodule

bind tmr_evt_gen tmr_evt_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap_i(wrap_i), .rep_zero(rep_zero),
  .trig_rst_i(trig_rst_i), .upd_dis_i(upd_dis_i), .upd_src_i(upd_src_i),
  .evt_we_i(evt_we_i), .evt_wdata_i(evt_wdata_i), .moe_set_i(moe_set_i),
  .upd_o(upd_o), .reinit_o(reinit_o), .ccg_o(ccg_o), .comg_o(comg_o),
  .uif_o(uif_o), .tif_o(tif_o), .bif_o(bif_o), .moe_o(moe_o)
);

// File: tb/tmr_evt_gen_bench.sv
module tmr_evt_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int RW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrap_i = 0, trig_rst_i = 0, upd_dis_i = 0, upd_src_i = 0;
  logic evt_we_i = 0, sts_clr_we_i = 0, moe_set_i = 0;
  logic [RW-1:0] rep_preset_i = '0;
  logic [15:0] evt_wdata_i = '0;
  logic [2:0] sts_clr_mask_i = '0;
  logic upd_o, reinit_o, comg_o, uif_o, tif_o, bif_o, moe_o;
  logic [NCH-1:0] ccg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_gen #(.NCH(NCH), .RW(RW)) u_tmr_evt_gen (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_i), .rep_preset_i(rep_preset_i),
    .trig_rst_i(trig_rst_i), .upd_dis_i(upd_dis_i), .upd_src_i(upd_src_i),
    .evt_we_i(evt_we_i), .evt_wdata_i(evt_wdata_i), .sts_clr_we_i(sts_clr_we_i),
    .sts_clr_mask_i(sts_clr_mask_i), .moe_set_i(moe_set_i), .upd_o(upd_o),
    .reinit_o(reinit_o), .ccg_o(ccg_o), .comg_o(comg_o), .uif_o(uif_o),
    .tif_o(tif_o), .bif_o(bif_o), .moe_o(moe_o)
  );

  // vector: wrap trig udis usrc we wdata[15:0] | upd reinit ccg[3:0] comg uif tif
  localparam int NV = 15;
  localparam logic [29:0] VEC [NV] = '{
    {5'b10000, 16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0}, // R1 wrap
    {5'b10100, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0}, // R4 wrap disabled
    {5'b00001, 16'h0001, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0}, // R2 sw update
    {5'b00011, 16'h0001, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0}, // R2 source gated
    {5'b00101, 16'h0001, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0}, // R4 sw disabled
    {5'b01000, 16'h0000, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0}, // R3 trigger
    {5'b01010, 16'h0000, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0}, // R3 source gated
    {5'b01100, 16'h0000, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0}, // R4 trigger disabled
    {5'b00001, 16'h001E, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0}, // R5 all channels
    {5'b00001, 16'h0004, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, 1'b0}, // R5 channel 1
    {5'b00001, 16'h0020, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0}, // R5 commutation
    {5'b00001, 16'h0040, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1}, // R7 trigger flag
    {5'b00001, 16'hFF00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0}, // R5 reserved ignored
    {5'b00000, 16'h00FF, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0}, // R5 no write strobe
    {5'b10011, 16'h0001, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0}  // R1 wrap beats source gate
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrap_i = 0; trig_rst_i = 0; evt_we_i = 0; evt_wdata_i = '0;
    sts_clr_we_i = 0; sts_clr_mask_i = '0; moe_set_i = 0;
  endtask

  task automatic wrap_once(input string tag, input logic exp_upd);
    @(negedge clk); idle(); wrap_i = 1; sts_clr_we_i = 1; sts_clr_mask_i = 3'b001;
    @(negedge clk); idle();
    chk(tag, {upd_o, uif_o}, {exp_upd, exp_upd});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset outputs", {upd_o, reinit_o, ccg_o, comg_o, uif_o, tif_o, bif_o, moe_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {wrap_i, trig_rst_i, upd_dis_i, upd_src_i, evt_we_i, evt_wdata_i} = VEC[i][29:9];
      sts_clr_we_i = 1; sts_clr_mask_i = 3'b111;
      @(negedge clk);
      chk($sformatf("R1-table vec%0d", i),
          {upd_o, reinit_o, ccg_o, comg_o, uif_o, tif_o}, VEC[i][8:0]);
      idle(); upd_dis_i = 0; upd_src_i = 0;
      @(negedge clk);
      chk($sformatf("R5 strobes cleared vec%0d", i), {upd_o, reinit_o, ccg_o, comg_o}, '0);
    end

    // R8 flag holds and clears selectively
    idle(); sts_clr_we_i = 1; sts_clr_mask_i = 3'b111;
    @(negedge clk); idle(); evt_we_i = 1; evt_wdata_i = 16'h00C1;
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    chk("R8 flags hold", {uif_o, tif_o, bif_o}, 3'b111);
    sts_clr_we_i = 1; sts_clr_mask_i = 3'b010;
    @(negedge clk); idle();
    chk("R8 clear trigger only", {uif_o, tif_o, bif_o}, 3'b101);
    sts_clr_we_i = 1; sts_clr_mask_i = 3'b100; evt_we_i = 1; evt_wdata_i = 16'h0080;
    @(negedge clk); idle();
    chk("R8 set wins over clear", bif_o, 1'b1);

    // R9 / R6 output enable
    moe_set_i = 1;
    @(negedge clk); idle();
    chk("R9 enable raised", moe_o, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 enable holds", moe_o, 1'b1);
    sts_clr_we_i = 1; sts_clr_mask_i = 3'b100;
    @(negedge clk); idle(); evt_we_i = 1; evt_wdata_i = 16'h0080;
    @(negedge clk); idle();
    chk("R6 break drops enable", {moe_o, bif_o}, 2'b01);
    moe_set_i = 1; evt_we_i = 1; evt_wdata_i = 16'h0080;
    @(negedge clk); idle();
    chk("R6 break wins over set", moe_o, 1'b0);

    // R1 repetition count with preset 2 (count is zero now)
    rep_preset_i = 8'd2;
    wrap_once("R1 rep zero updates", 1'b1);
    wrap_once("R1 rep 2 no update", 1'b0);
    wrap_once("R1 rep 1 no update", 1'b0);
    wrap_once("R1 rep back to zero", 1'b1);
    wrap_once("R1 rep reloaded", 1'b0);
    // R1 software update reloads the count (now 1 -> reload 2)
    @(negedge clk); idle(); evt_we_i = 1; evt_wdata_i = 16'h0001;
    @(negedge clk); idle();
    wrap_once("R1 reload by sw update", 1'b0);
    wrap_once("R1 after reload 1", 1'b0);
    wrap_once("R1 after reload 0", 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule